// File: doc/BRIEF.md
# Two-Address Instruction Word Decoder

This block takes one 16-bit instruction word per cycle and turns it into a record that an execution pipeline can use directly. It sorts the word into one of three formats: single-operand, conditional jump or two-operand. It then maps the opcode bits onto one flat operation number and reports the operand-size flag and the register numbers. It also resolves the addressing mode of each operand into a named mode code.

Two registers reuse the source mode field in special ways. With the status register as source, the field selects absolute addressing or one of the constants 4 and 8. With the constant register, all four field values select an inline constant: 0, 1, 2 or -1. The decoder therefore reports the generated constant itself, the number of extension words a fetch unit must read after the instruction, and the autoincrement step. For jumps it reports the byte displacement. Encodings that are not defined, and size-less operations that carry the byte bit, are flagged as illegal.

The result is registered, so the record for a word appears one cycle after the word is presented.

Top module: `insn_decode16`

## Requirements
- R1: After synchronous reset `dec_valid` is 0. A word presented with `in_valid`=1 gives `dec_valid`=1 on the next cycle, and `in_valid`=0 gives `dec_valid`=0 on the next cycle.
- R2: Format code `dec_class`: 3 (two-operand) when bits 15:12 are 4 or more; 2 (jump) when bits 15:13 are 001; 1 (single-operand) when bits 15:10 are 000100. For a jump, both mode outputs are 8 (none) and both register outputs are 0.
- R3: Operation number `dec_op`:
  - single-operand: bits 9:7, where 0=rotate-through-carry, 1=byte-swap, 2=arithmetic shift right, 3=sign-extend, 4=push, 5=call and 6=return-from-interrupt;
  - jump: 8 plus bits 12:10;
  - two-operand: 16 plus (bits 15:12 minus 4).
- R4: For a jump, `dec_jump_disp` is bits 9:0 taken as a signed value, multiplied by two and sign-extended to XLEN. The output is 0 for the other formats.
- R5: Mode codes are 0 register, 1 indexed, 2 indirect, 3 autoincrement, 4 PC-relative, 5 immediate, 6 absolute, 7 constant and 8 none.
  - The source field is bits 5:4. For a general register it gives 0, 1, 2 and 3.
  - The source register is bits 11:8 for two-operand words and bits 3:0 for single-operand words.
  - Return-from-interrupt has no operand: mode 8, register 0.
- R6: With register 0 as source, field value 1 gives mode 4 and value 3 gives mode 5. With register 2 as source, field value 1 gives mode 6.
- R7: Inline constants set `dec_const_en`=1 and source mode 7, with no extension word.
  - Register 2: field 2 gives 4 and field 3 gives 8.
  - Register 3: fields 0, 1, 2 and 3 give 0, 1, 2 and all-ones (-1).
  - Otherwise `dec_const_en` and `dec_const` are 0.
- R8: Two-operand destination register is bits 3:0.
  - Bit 7 = 0 gives mode 0.
  - Bit 7 = 1 gives mode 4 for register 0, mode 6 for register 2 and mode 1 for any other register.
  - Non-two-operand words give destination mode 8 and register 0.
- R9: `dec_ext_words` counts one word for a source in mode 1, 4, 5 or 6, plus one for a destination in mode 1, 4 or 6. The count is at most 2.
- R10: `dec_inc_step`:
  - 2 for source modes 3 and 5 when the register is 0 or 1;
  - for other registers in mode 3: 1 with the byte bit set, 2 with it clear;
  - 0 otherwise.
- R11: The following words are illegal:
  - bits 15:12 below 4 that are neither jump nor single-operand;
  - single-operand with bits 9:7 = 7;
  - byte-swap, sign-extend or call with bit 6 set;
  - return-from-interrupt with any of bits 6:0 set.

  An illegal word gives `dec_illegal`=1, class 0, op 31, both modes 8 and all other fields 0.
- R12: `dec_byte` copies bit 6 for legal single- and two-operand words and is 0 for jumps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 16 | Instruction word |
| dec_valid | output | 1 | Decoded record valid |
| dec_class | output | 2 | Format code |
| dec_op | output | 5 | Flat operation number |
| dec_byte | output | 1 | Byte-size operation |
| dec_src_mode | output | 4 | Source addressing mode code |
| dec_dst_mode | output | 4 | Destination addressing mode code |
| dec_src_reg | output | 4 | Source register number |
| dec_dst_reg | output | 4 | Destination register number |
| dec_const_en | output | 1 | Source is an inline constant |
| dec_const | output | XLEN | Inline constant value |
| dec_ext_words | output | 2 | Extension words to fetch |
| dec_inc_step | output | 2 | Autoincrement amount in bytes |
| dec_jump_disp | output | XLEN | Jump byte displacement |
| dec_illegal | output | 1 | Illegal encoding |

## Verification
The bench builds the decoder with XLEN=16, so negative constants and jump displacements appear as full 16-bit two's-complement values. At that width the extreme offsets 0x1FF and 0x200 show the sign-extension edge. The bench sweeps all twelve two-operand opcodes and all eight jump conditions. It also covers every register-0/2/3 source field value, the byte-versus-word step with the stack pointer, and each illegal pattern. Idle cycles placed between words show that the valid output follows the input.

// File: rtl/insn_decode16_pkg.sv
package insn_decode16_pkg;

    localparam int IW = 16;

    typedef enum logic [1:0] {
        CLS_BAD = 2'd0,
        CLS_ONE = 2'd1,
        CLS_JMP = 2'd2,
        CLS_TWO = 2'd3
    } cls_e;

    typedef enum logic [3:0] {
        AM_REG     = 4'd0,
        AM_INDEX   = 4'd1,
        AM_IND     = 4'd2,
        AM_AUTOINC = 4'd3,
        AM_SYMB    = 4'd4,
        AM_IMM     = 4'd5,
        AM_ABS     = 4'd6,
        AM_CONST   = 4'd7,
        AM_NONE    = 4'd8
    } am_e;

    localparam logic [4:0] OP_NONE  = 5'd31;
    localparam logic [2:0] SEL_SWAP = 3'd1;
    localparam logic [2:0] SEL_SEXT = 3'd3;
    localparam logic [2:0] SEL_CALL = 3'd5;
    localparam logic [2:0] SEL_RETI = 3'd6;
    localparam logic [2:0] SEL_RSVD = 3'd7;

    localparam logic [3:0] REG_PC = 4'd0;
    localparam logic [3:0] REG_SP = 4'd1;
    localparam logic [3:0] REG_SR = 4'd2;
    localparam logic [3:0] REG_CG = 4'd3;

    typedef struct packed {
        cls_e        cls;
        logic [4:0]  op;
        logic        byte_op;
        logic        illegal;
        logic        has_src;
        logic        has_dst;
        logic [10:0] jdisp;
    } fmt_t;

    typedef struct packed {
        am_e        mode;
        logic       ext;
        logic       const_en;
        logic [4:0] kval;
        logic [1:0] step;
    } src_t;

    typedef struct packed {
        am_e  mode;
        logic ext;
    } dst_t;

    function automatic logic [1:0] step_for(logic [3:0] rg, logic byte_op);
        if (rg == REG_PC || rg == REG_SP) return 2'd2;
        return byte_op ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/insn_decode16_fmt.sv
module insn_decode16_fmt
    import insn_decode16_pkg::*;
(
    input  logic [IW-1:0] word,
    output fmt_t          fmt
);
    logic [2:0] sel;
    logic       bad;

    assign sel = word[9:7];

    always_comb begin
        fmt       = '0;
        fmt.cls   = CLS_BAD;
        fmt.op    = OP_NONE;
        bad       = 1'b0;
        if (word[15:12] >= 4'd4) begin
            fmt.cls     = CLS_TWO;
            fmt.op      = 5'd16 + {1'b0, word[15:12]} - 5'd4;
            fmt.byte_op = word[6];
            fmt.has_src = 1'b1;
            fmt.has_dst = 1'b1;
        end else if (word[15:13] == 3'b001) begin
            fmt.cls   = CLS_JMP;
            fmt.op    = {2'b01, word[12:10]};
            fmt.jdisp = {word[9:0], 1'b0};
        end else if (word[15:10] == 6'b000100) begin
            fmt.cls = CLS_ONE;
            fmt.op  = {2'b00, sel};
            unique case (sel)
                SEL_RSVD: bad = 1'b1;
                SEL_RETI: bad = (word[6:0] != 7'd0);
                SEL_SWAP, SEL_SEXT, SEL_CALL: begin
                    bad         = word[6];
                    fmt.has_src = 1'b1;
                end
                default: begin
                    fmt.byte_op = word[6];
                    fmt.has_src = 1'b1;
                end
            endcase
        end else begin
            bad = 1'b1;
        end
        if (bad) begin
            fmt         = '0;
            fmt.cls     = CLS_BAD;
            fmt.op      = OP_NONE;
            fmt.illegal = 1'b1;
        end
    end
endmodule

// File: rtl/insn_decode16_src.sv
module insn_decode16_src
    import insn_decode16_pkg::*;
(
    input  logic       en,
    input  logic [3:0] rg,
    input  logic [1:0] as_f,
    input  logic       byte_op,
    output src_t       src
);
    always_comb begin
        src      = '0;
        src.mode = AM_NONE;
        if (en) begin
            unique case (rg)
                REG_CG: begin
                    src.mode     = AM_CONST;
                    src.const_en = 1'b1;
                    src.kval     = (as_f == 2'd3) ? 5'h1F : {3'b000, as_f};
                end
                REG_SR: begin
                    unique case (as_f)
                        2'd0: src.mode = AM_REG;
                        2'd1: begin src.mode = AM_ABS; src.ext = 1'b1; end
                        2'd2: begin src.mode = AM_CONST; src.const_en = 1'b1; src.kval = 5'd4; end
                        default: begin src.mode = AM_CONST; src.const_en = 1'b1; src.kval = 5'd8; end
                    endcase
                end
                REG_PC: begin
                    unique case (as_f)
                        2'd0: src.mode = AM_REG;
                        2'd1: begin src.mode = AM_SYMB; src.ext = 1'b1; end
                        2'd2: src.mode = AM_IND;
                        default: begin src.mode = AM_IMM; src.ext = 1'b1; src.step = 2'd2; end
                    endcase
                end
                default: begin
                    unique case (as_f)
                        2'd0: src.mode = AM_REG;
                        2'd1: begin src.mode = AM_INDEX; src.ext = 1'b1; end
                        2'd2: src.mode = AM_IND;
                        default: begin src.mode = AM_AUTOINC; src.step = step_for(rg, byte_op); end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/insn_decode16_dst.sv
module insn_decode16_dst
    import insn_decode16_pkg::*;
(
    input  logic       en,
    input  logic [3:0] rg,
    input  logic       ad_f,
    output dst_t       dst
);
    always_comb begin
        dst.mode = AM_NONE;
        dst.ext  = 1'b0;
        if (en) begin
            dst.ext = ad_f;
            if (!ad_f)             dst.mode = AM_REG;
            else if (rg == REG_PC) dst.mode = AM_SYMB;
            else if (rg == REG_SR) dst.mode = AM_ABS;
            else                   dst.mode = AM_INDEX;
        end
    end
endmodule

// File: rtl/insn_decode16.sv
module insn_decode16
    import insn_decode16_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [IW-1:0]   in_word,
    output logic            dec_valid,
    output logic [1:0]      dec_class,
    output logic [4:0]      dec_op,
    output logic            dec_byte,
    output logic [3:0]      dec_src_mode,
    output logic [3:0]      dec_dst_mode,
    output logic [3:0]      dec_src_reg,
    output logic [3:0]      dec_dst_reg,
    output logic            dec_const_en,
    output logic [XLEN-1:0] dec_const,
    output logic [1:0]      dec_ext_words,
    output logic [1:0]      dec_inc_step,
    output logic [XLEN-1:0] dec_jump_disp,
    output logic            dec_illegal
);
    localparam int KPAD = XLEN - 5;
    localparam int JPAD = XLEN - 11;

    fmt_t       fmt;
    src_t       src;
    dst_t       dst;
    logic [3:0] src_rg;
    logic [3:0] dst_rg;

    insn_decode16_fmt u_fmt (.word(in_word), .fmt(fmt));

    assign src_rg = !fmt.has_src ? 4'd0 : (fmt.has_dst ? in_word[11:8] : in_word[3:0]);
    assign dst_rg = fmt.has_dst ? in_word[3:0] : 4'd0;

    insn_decode16_src u_src (
        .en(fmt.has_src), .rg(src_rg), .as_f(in_word[5:4]),
        .byte_op(fmt.byte_op), .src(src)
    );

    insn_decode16_dst u_dst (
        .en(fmt.has_dst), .rg(dst_rg), .ad_f(in_word[7]), .dst(dst)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid     <= 1'b0;
            dec_class     <= CLS_BAD;
            dec_op        <= OP_NONE;
            dec_byte      <= 1'b0;
            dec_src_mode  <= AM_NONE;
            dec_dst_mode  <= AM_NONE;
            dec_src_reg   <= '0;
            dec_dst_reg   <= '0;
            dec_const_en  <= 1'b0;
            dec_const     <= '0;
            dec_ext_words <= '0;
            dec_inc_step  <= '0;
            dec_jump_disp <= '0;
            dec_illegal   <= 1'b0;
        end else begin
            dec_valid     <= in_valid;
            dec_class     <= fmt.cls;
            dec_op        <= fmt.op;
            dec_byte      <= fmt.byte_op;
            dec_src_mode  <= src.mode;
            dec_dst_mode  <= dst.mode;
            dec_src_reg   <= src_rg;
            dec_dst_reg   <= dst_rg;
            dec_const_en  <= src.const_en;
            dec_const     <= {{KPAD{src.kval[4]}}, src.kval};
            dec_ext_words <= {1'b0, src.ext} + {1'b0, dst.ext};
            dec_inc_step  <= src.step;
            dec_jump_disp <= {{JPAD{fmt.jdisp[10]}}, fmt.jdisp};
            dec_illegal   <= fmt.illegal;
        end
    end
endmodule

// File: rtl/insn_decode16_chk.sv
module insn_decode16_chk #(
    parameter int XLEN = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            dec_valid,
    input logic [1:0]      dec_class,
    input logic [3:0]      dec_src_mode,
    input logic [3:0]      dec_dst_mode,
    input logic            dec_const_en,
    input logic [1:0]      dec_ext_words,
    input logic [1:0]      dec_inc_step,
    input logic [XLEN-1:0] dec_jump_disp,
    input logic            dec_illegal
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> dec_valid);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !dec_valid);
    assert_jump_no_operand_R2: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_class == 2'd2) |-> (dec_src_mode == 4'd8 && dec_dst_mode == 4'd8));
    assert_even_disp_R4: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> !dec_jump_disp[0]);
    assert_const_no_fetch_R7: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_const_en) |-> (dec_src_mode == 4'd7 && dec_ext_words <= 2'd1));
    assert_ext_bound_R9: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> dec_ext_words <= 2'd2);
    assert_step_mode_R10: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_inc_step != 2'd0) |-> (dec_src_mode == 4'd3 || dec_src_mode == 4'd5));
    assert_illegal_clean_R11: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_illegal) |-> (dec_class == 2'd0 && dec_ext_words == 2'd0 && !dec_const_en));
endmodule

bind insn_decode16 insn_decode16_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_insn_decode16.sv
`timescale 1ns/1ps
module sim_insn_decode16;
    localparam int XLEN = 16;
    localparam int VW   = 62;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [15:0]     in_word = '0;
    logic            dec_valid, dec_byte, dec_const_en, dec_illegal;
    logic [1:0]      dec_class, dec_ext_words, dec_inc_step;
    logic [4:0]      dec_op;
    logic [3:0]      dec_src_mode, dec_dst_mode, dec_src_reg, dec_dst_reg;
    logic [XLEN-1:0] dec_const, dec_jump_disp;

    insn_decode16 #(.XLEN(XLEN)) u0 (.*);

    always #2.5 clk = ~clk;

    typedef struct {
        logic            v;
        logic [VW-1:0]   bits;
        string           tag;
        int              stamp;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [VW-1:0] actual_bits();
        return {dec_class, dec_op, dec_byte, dec_src_mode, dec_dst_mode, dec_src_reg,
                dec_dst_reg, dec_const_en, dec_const, dec_ext_words, dec_inc_step,
                dec_jump_disp, dec_illegal};
    endfunction

    // Reference decode written from the requirement text
    function automatic logic [VW-1:0] model(logic [15:0] w);
        logic [1:0]  c = 2'd0;   logic [4:0] op = 5'd31; logic b = 1'b0;
        logic [3:0]  sm = 4'd8;  logic [3:0] dm = 4'd8;
        logic [3:0]  sr = 4'd0;  logic [3:0] dr = 4'd0;
        logic        ce = 1'b0;  logic [15:0] k = 16'd0;
        logic [1:0]  ex = 2'd0;  logic [1:0] st = 2'd0;
        logic [15:0] d = 16'd0;  logic il = 1'b0;
        logic        src_on = 1'b0;
        logic [1:0]  a = w[5:4];
        if (w[15:12] >= 4'd4) begin                 // R2 R3 R8 R12
            c = 2'd3; op = 5'(w[15:12]) + 5'd12; b = w[6];
            sr = w[11:8]; dr = w[3:0]; src_on = 1'b1;
            if (w[7] == 1'b0) dm = 4'd0;
            else begin
                ex = 2'd1;
                dm = (dr == 4'd0) ? 4'd4 : (dr == 4'd2) ? 4'd6 : 4'd1;
            end
        end else if (w[15:13] == 3'b001) begin      // R4
            c = 2'd2; op = 5'd8 + 5'(w[12:10]);
            d = 16'($signed(w[9:0])) <<< 1;
        end else if (w[15:10] == 6'b000100) begin
            if (w[9:7] == 3'd7) il = 1'b1;
            else if (w[9:7] == 3'd6) begin
                if (w[6:0] != 0) il = 1'b1;
                else begin c = 2'd1; op = 5'd6; end
            end else if ((w[9:7] == 3'd1 || w[9:7] == 3'd3 || w[9:7] == 3'd5) && w[6]) il = 1'b1;
            else begin
                c = 2'd1; op = 5'(w[9:7]); b = w[6]; sr = w[3:0]; src_on = 1'b1;
            end
        end else il = 1'b1;
        if (src_on) begin                           // R5 R6 R7 R10
            if (sr == 4'd3) begin
                sm = 4'd7; ce = 1'b1;
                k = (a == 2'd3) ? 16'hFFFF : 16'(a);
            end else if (sr == 4'd2 && a >= 2'd2) begin
                sm = 4'd7; ce = 1'b1; k = (a == 2'd2) ? 16'd4 : 16'd8;
            end else if (a == 2'd1) begin
                ex = ex + 2'd1;
                sm = (sr == 4'd0) ? 4'd4 : (sr == 4'd2) ? 4'd6 : 4'd1;
            end else if (a == 2'd2) sm = 4'd2;
            else if (a == 2'd3) begin
                sm = (sr == 4'd0) ? 4'd5 : 4'd3;
                if (sr == 4'd0 || sr == 4'd1) st = 2'd2;
                else st = b ? 2'd1 : 2'd2;
                if (sr == 4'd0) ex = ex + 2'd1;
            end else sm = 4'd0;
        end
        return {c, op, b, sm, dm, sr, dr, ce, k, ex, st, d, il};
    endfunction

    task automatic drive(input logic v, input logic [15:0] w, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = v;
        in_word  = w;
        e.v = v; e.bits = model(w); e.tag = tag; e.stamp = cyc;
        q.push_back(e);
    endtask

    // Monitor: compare each result one edge after its word
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0 && q[0].stamp < cyc) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (dec_valid !== e.v) begin
                    errors++;
                    $display("FAIL R1 valid (%s) actual=%0b expected=%0b", e.tag, dec_valid, e.v);
                end else if (e.v && actual_bits() !== e.bits) begin
                    errors++;
                    $display("FAIL %s word=%h actual=%h expected=%h", e.tag, u0.in_word, actual_bits(), e.bits);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;   // R1 reset state
        if (dec_valid !== 1'b0 || dec_illegal !== 1'b0 || dec_ext_words !== 2'd0) begin
            errors++;
            $display("FAIL R1 reset actual=%b%b%b expected=000", dec_valid, dec_illegal, dec_ext_words);
        end
        rst = 1'b0;
        // R2 R3 R12: every two-operand opcode, word and byte
        for (int h = 4; h < 16; h++) begin
            drive(1'b1, {4'(h), 12'h506}, "R3 two-op word");
            drive(1'b1, {4'(h), 12'h546}, "R12 two-op byte");
        end
        // R4: every jump condition with edge offsets
        for (int cc = 0; cc < 8; cc++) begin
            drive(1'b1, {3'b001, 3'(cc), 10'h1FF}, "R4 jump max positive");
            drive(1'b1, {3'b001, 3'(cc), 10'h200}, "R4 jump most negative");
        end
        drive(1'b1, 16'h23FF, "R4 jump minus one");
        drive(1'b0, 16'h4506, "R1 idle");
        drive(1'b1, 16'h4925, "R5 indirect general");
        drive(1'b1, 16'h4496, "R9 indexed both, two words");
        drive(1'b1, 16'h4092, "R6 pc-relative source, absolute dest");
        drive(1'b1, 16'h4590, "R8 pc-relative dest");
        drive(1'b1, 16'h4215, "R6 absolute source");
        drive(1'b1, 16'h4035, "R6 immediate source");
        drive(1'b1, 16'h4130, "R10 sp autoinc word");
        drive(1'b1, 16'h4170, "R10 sp autoinc byte");
        drive(1'b1, 16'h5477, "R10 general autoinc byte");
        drive(1'b1, 16'h5437, "R10 general autoinc word");
        for (int a = 0; a < 4; a++) begin
            drive(1'b1, {8'h43, 2'b00, 2'(a), 4'h5}, "R7 constant register");
            drive(1'b1, {8'h42, 2'b00, 2'(a), 4'h5}, "R7 status register field");
        end
        drive(1'b1, 16'h4396, "R7 constant source with indexed dest");
        drive(1'b0, 16'h0000, "R1 idle");
        // single-operand forms
        drive(1'b1, 16'h1005, "R5 single register");
        drive(1'b1, 16'h1076, "R10 single autoinc byte");
        drive(1'b1, 16'h1145, "R12 single byte shift");
        drive(1'b1, 16'h1230, "R6 push immediate");
        drive(1'b1, 16'h1294, "R9 call indexed");
        drive(1'b1, 16'h1085, "R3 byte swap");
        drive(1'b1, 16'h1185, "R3 sign extend");
        drive(1'b1, 16'h1213, "R7 push constant one");
        drive(1'b1, 16'h1300, "R5 return no operand");
        // R11 illegal words
        drive(1'b1, 16'h10C5, "R11 byte swap with byte bit");
        drive(1'b1, 16'h11C5, "R11 sign extend with byte bit");
        drive(1'b1, 16'h12C4, "R11 call with byte bit");
        drive(1'b1, 16'h1301, "R11 return with operand bits");
        drive(1'b1, 16'h1340, "R11 return with byte bit");
        drive(1'b1, 16'h1380, "R11 reserved single select");
        drive(1'b1, 16'h0000, "R11 zero word");
        drive(1'b1, 16'h1400, "R11 unclassified 0001_01");
        drive(1'b1, 16'h1800, "R11 unclassified 0001_1");
        drive(1'b1, 16'h0FFF, "R11 unclassified 0000");
        drive(1'b1, 16'h4506, "R2 legal after illegal");
        drive(1'b0, 16'h0000, "R1 final idle");
        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            errors++; checks++;
            $display("FAIL R1 results missing actual=%0d expected=0", q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule